// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block sits beside a BCD calendar counter and watches the running time for a programmed alarm point. Software loads an alarm minute and an alarm hour, both in BCD, together with a seven-bit weekday selection mask. It also sets an enable bit in a control register. The counter supplies its current BCD minute, BCD hour and weekday number, and it pulses a strobe each time it enters a new minute.

On each strobe the block takes a snapshot of the current time and compares it in the following cycle. When the minute matches, the hour matches and the mask bit for the current weekday is set, a sticky alarm flag is raised. The flag remains set until software clears it by writing a one. The interrupt output is the flag gated by the enable bit. The resolution is one minute, and seconds play no part. Because the day is chosen from a weekday mask, an alarm can fall at most one week ahead.

The sequencer has two states. ST_WAIT idles until a strobe arrives; the transition WAIT→CHECK happens on a strobe. ST_CHECK compares the snapshot taken on entry and sets the flag on a hit. It then takes CHECK→WAIT when no strobe is present, or stays in CHECK (CHECK→CHECK) when a further strobe arrives, which takes a fresh snapshot.

Top module: `wk_alarm_top`

## Requirements
- R1: After reset, alarm_flag and irq are 0, the alarm minute and hour are 0x00, the weekday mask is empty and the enable bit is 0. With those settings, a strobe at 00:00 on any day leaves the flag at 0.
- R2: The time is compared only when min_tick is sampled high. The flag rises at the second rising edge, counting the edge that samples the strobe as the first. A matching time with no strobe never sets the flag.
- R3: A hit requires three things: cur_min equals the alarm minute in all 8 BCD bits, cur_hour equals the alarm hour in all 8 BCD bits, and the mask bit at position cur_wday is 1.
- R4: The mask may select several weekdays at once, and a match on any selected day is a hit.
- R5: A cur_wday value of 7 selects no mask bit and never produces a hit.
- R6: The flag is sticky. Writing select code 4 with data bit 0 = 1 clears it, and the same write with bit 0 = 0 has no effect. If a clear and a hit land in the same cycle, the hit wins and the flag stays 1.
- R7: irq is 1 exactly when the flag is 1 and the enable bit, bit 4 of the control register, is 1. A hit sets the flag even while the enable bit is 0, so setting the enable bit afterwards raises irq.
- R8: Writing 0x00 to the control register drops irq in the cycle after the write edge, and the flag stays set.
- R9: The select codes are: 0 for alarm minute, 1 for alarm hour, 2 for weekday mask (data bit n selects weekday n, n = 0 to 6), 3 for control, and 4 for flag clear. Writes with codes 5 to 7 change nothing.
- R10: A strobe whose time does not match leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write data |
| cur_min | input | 8 | Current BCD minute from the counter |
| cur_hour | input | 8 | Current BCD hour from the counter |
| cur_wday | input | 3 | Current weekday number, 0 to 6 |
| min_tick | input | 1 | One-cycle pulse when the counter enters a new minute |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt: the flag gated by the enable bit |

## Verification
The assertions check the following on every cycle:
- The flag holds unless it is cleared.
- The flag only rises two edges after a strobe.
- irq never appears without the flag.
- A clear write with no coincident hit empties the flag.
- Disabling the alarm removes irq at once.

Only the bench scenarios can show that the comparison is correct for particular minute, hour and weekday values. The same applies to the multi-day mask, to weekday 7, to the ignored select codes and to the priority of a hit over a clear in the same cycle. Those cases are driven as directed sequences and then as seeded random times that land on the alarm about a quarter of the time.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_CHECK = 1'b1
    } wk_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_MIN  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_HOUR = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MASK = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CLR  = 3'd4;

    localparam int EN_BIT  = 4;
    localparam int CLR_BIT = 0;

endpackage

// File: rtl/wk_alarm_regs.sv
module wk_alarm_regs
    import wk_alarm_pkg::*;
#(
    parameter int BCD_W    = 8,
    parameter int NUM_DAYS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [BCD_W-1:0]    cfg_wdata,
    output logic [BCD_W-1:0]    al_min,
    output logic [BCD_W-1:0]    al_hour,
    output logic [NUM_DAYS-1:0] al_mask,
    output logic                al_en,
    output logic                clr_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_min  <= '0;
            al_hour <= '0;
            al_mask <= '0;
            al_en   <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_MIN:  al_min  <= cfg_wdata;
                SEL_HOUR: al_hour <= cfg_wdata;
                SEL_MASK: al_mask <= cfg_wdata[NUM_DAYS-1:0];
                SEL_CTRL: al_en   <= cfg_wdata[EN_BIT];
                default:  ;
            endcase
        end
    end

    assign clr_req = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[CLR_BIT];

endmodule

// File: rtl/wk_alarm_cmp.sv
module wk_alarm_cmp #(
    parameter int BCD_W    = 8,
    parameter int NUM_DAYS = 7,
    parameter int DAY_W    = 3
) (
    input  logic [BCD_W-1:0]    snap_min,
    input  logic [BCD_W-1:0]    snap_hour,
    input  logic [DAY_W-1:0]    snap_wday,
    input  logic [BCD_W-1:0]    al_min,
    input  logic [BCD_W-1:0]    al_hour,
    input  logic [NUM_DAYS-1:0] al_mask,
    output logic                hit
);

    logic [NUM_DAYS-1:0] day_sel;

    for (genvar d = 0; d < NUM_DAYS; d++) begin : g_day
        assign day_sel[d] = al_mask[d] && (snap_wday == DAY_W'(d));
    end

    assign hit = (snap_min == al_min) && (snap_hour == al_hour) && (|day_sel);

endmodule

// File: rtl/wk_alarm_fsm.sv
module wk_alarm_fsm
    import wk_alarm_pkg::*;
#(
    parameter int BCD_W = 8,
    parameter int DAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             min_tick,
    input  logic [BCD_W-1:0] cur_min,
    input  logic [BCD_W-1:0] cur_hour,
    input  logic [DAY_W-1:0] cur_wday,
    input  logic             hit,
    input  logic             clr_req,
    input  logic             al_en,
    output logic [BCD_W-1:0] snap_min,
    output logic [BCD_W-1:0] snap_hour,
    output logic [DAY_W-1:0] snap_wday,
    output logic             set_pulse,
    output logic             flag_q,
    output logic             irq
);

    wk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (min_tick) state_d = ST_CHECK;
            ST_CHECK: state_d = min_tick ? ST_CHECK : ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    assign set_pulse = (state_q == ST_CHECK) && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_min  <= '0;
            snap_hour <= '0;
            snap_wday <= '0;
            flag_q    <= 1'b0;
        end else begin
            if (min_tick) begin
                snap_min  <= cur_min;
                snap_hour <= cur_hour;
                snap_wday <= cur_wday;
            end
            if (set_pulse)    flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && al_en;

endmodule

// File: rtl/wk_alarm_top.sv
module wk_alarm_top
    import wk_alarm_pkg::*;
#(
    parameter int BCD_W    = 8,
    parameter int NUM_DAYS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [7:0]       cur_min,
    input  logic [7:0]       cur_hour,
    input  logic [2:0]       cur_wday,
    input  logic             min_tick,
    output logic             alarm_flag,
    output logic             irq
);

    localparam int DAY_W = $clog2(NUM_DAYS + 1);

    logic [BCD_W-1:0]    al_min, al_hour, snap_min, snap_hour;
    logic [NUM_DAYS-1:0] al_mask;
    logic [DAY_W-1:0]    snap_wday;
    logic                al_en, clr_req, hit, set_pulse;

    wk_alarm_regs #(.BCD_W(BCD_W), .NUM_DAYS(NUM_DAYS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .al_min    (al_min),
        .al_hour   (al_hour),
        .al_mask   (al_mask),
        .al_en     (al_en),
        .clr_req   (clr_req)
    );

    wk_alarm_cmp #(.BCD_W(BCD_W), .NUM_DAYS(NUM_DAYS), .DAY_W(DAY_W)) u_cmp (
        .snap_min  (snap_min),
        .snap_hour (snap_hour),
        .snap_wday (snap_wday),
        .al_min    (al_min),
        .al_hour   (al_hour),
        .al_mask   (al_mask),
        .hit       (hit)
    );

    wk_alarm_fsm #(.BCD_W(BCD_W), .DAY_W(DAY_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_tick  (min_tick),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .cur_wday  (cur_wday),
        .hit       (hit),
        .clr_req   (clr_req),
        .al_en     (al_en),
        .snap_min  (snap_min),
        .snap_hour (snap_hour),
        .snap_wday (snap_wday),
        .set_pulse (set_pulse),
        .flag_q    (alarm_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/wk_alarm_chk.sv
module wk_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_sel,
    input logic [7:0] cfg_wdata,
    input logic       min_tick,
    input logic       set_pulse,
    input logic       alarm_flag,
    input logic       irq
);

    logic clr_wr, ctrl_off_wr;
    assign clr_wr      = cfg_we && (cfg_sel == 3'd4) && cfg_wdata[0];
    assign ctrl_off_wr = cfg_we && (cfg_sel == 3'd3) && !cfg_wdata[4];

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_wr) |=> alarm_flag); // R6

    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(min_tick, 2)); // R2

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alarm_flag); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_pulse) |=> !alarm_flag); // R6

    AST_DISABLE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off_wr |=> !irq); // R8

endmodule

bind wk_alarm_top wk_alarm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .min_tick   (min_tick),
    .set_pulse  (set_pulse),
    .alarm_flag (alarm_flag),
    .irq        (irq)
);

// File: tb/tb_wk_alarm_top.sv
module tb_wk_alarm_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cur_min = '0;
    logic [7:0] cur_hour = '0;
    logic [2:0] cur_wday = '0;
    logic       min_tick = 1'b0;
    logic       alarm_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench-side model of the programmed registers.
    int        m_min = 0, m_hour = 0;
    logic [6:0] m_mask = '0;
    bit        m_en = 1'b0;
    bit        m_flag = 1'b0;

    always #4 clk = ~clk;

    wk_alarm_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .min_tick(min_tick), .alarm_flag(alarm_flag), .irq(irq)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic bit exp_hit(input int mi, input int hr, input int wd);
        return (mi == m_min) && (hr == m_hour) && (wd < 7) && m_mask[wd % 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tick(input int mi, input int hr, input int wd);
        @(negedge clk);
        cur_min = to_bcd(mi); cur_hour = to_bcd(hr); cur_wday = 3'(wd);
        min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
        @(negedge clk);
        if (exp_hit(mi, hr, wd)) m_flag = 1'b1;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after reset", alarm_flag, 0);
        chk("R1 irq after reset", irq, 0);
        tick(0, 0, 0);
        chk("R1 empty mask no hit", alarm_flag, 0);

        wr(3'd0, 8'h30); wr(3'd1, 8'h07); wr(3'd2, 8'h04); wr(3'd3, 8'h10);
        m_min = 30; m_hour = 7; m_mask = 7'h04; m_en = 1'b1;

        tick(30, 7, 3);
        chk("R3 wrong weekday", alarm_flag, 0);
        tick(31, 7, 2);
        chk("R10 minute mismatch", alarm_flag, 0);
        tick(30, 8, 2);
        chk("R3 hour mismatch", alarm_flag, 0);

        // R2: no strobe, matching time held for several cycles
        @(negedge clk);
        cur_min = 8'h30; cur_hour = 8'h07; cur_wday = 3'd2;
        repeat (5) @(negedge clk);
        chk("R2 no tick no hit", alarm_flag, 0);

        // R2: latency, not set after first edge, set after second
        @(negedge clk);
        min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
        chk("R2 not yet after first edge", alarm_flag, 0);
        @(negedge clk);
        chk("R2 set after second edge", alarm_flag, 1);
        chk("R7 irq with enable", irq, 1);
        m_flag = 1'b1;

        tick(0, 0, 0);
        chk("R10 nonmatch keeps flag", alarm_flag, 1);
        wr(3'd4, 8'h00);
        chk("R6 clear bit0=0 ignored", alarm_flag, 1);
        wr(3'd5, 8'h01); wr(3'd7, 8'hFF);
        chk("R9 unused codes ignored", alarm_flag, 1);
        wr(3'd4, 8'h01); m_flag = 1'b0;
        chk("R6 clear", alarm_flag, 0);
        wr(3'd6, 8'h00);
        tick(30, 7, 2);
        chk("R9 alarm kept after unused code", alarm_flag, 1);
        wr(3'd4, 8'h01); m_flag = 1'b0;

        // R4 / R5: two selected days and weekday 7
        wr(3'd2, 8'h41); m_mask = 7'h41;
        tick(30, 7, 6);
        chk("R4 day 6 selected", alarm_flag, 1);
        wr(3'd4, 8'h01);
        tick(30, 7, 0);
        chk("R4 day 0 selected", alarm_flag, 1);
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h7F); m_mask = 7'h7F;
        tick(30, 7, 7);
        chk("R5 weekday 7 never hits", alarm_flag, 0);
        m_flag = 1'b0;

        // R7 / R8: enable gating
        wr(3'd3, 8'h00); m_en = 1'b0;
        tick(30, 7, 1);
        chk("R7 flag sets while disabled", alarm_flag, 1);
        chk("R7 irq gated off", irq, 0);
        wr(3'd3, 8'h10);
        chk("R7 irq after enabling", irq, 1);
        wr(3'd3, 8'h00);
        chk("R8 control zero drops irq", irq, 0);
        chk("R8 flag kept", alarm_flag, 1);
        wr(3'd3, 8'h10); m_en = 1'b1;
        wr(3'd4, 8'h01); m_flag = 1'b0;

        // R6: hit and clear in the same cycle, hit wins
        @(negedge clk);
        cur_min = 8'h30; cur_hour = 8'h07; cur_wday = 3'd4; min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 8'h01;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R6 hit beats clear", alarm_flag, 1);
        wr(3'd4, 8'h01); m_flag = 1'b0;

        // Seeded random phase
        for (int i = 0; i < 400; i++) begin
            if (i % 80 == 0) begin
                m_min = $urandom % 60; m_hour = $urandom % 24;
                m_mask = 7'($urandom); m_en = 1'($urandom);
                wr(3'd0, to_bcd(m_min)); wr(3'd1, to_bcd(m_hour));
                wr(3'd2, {1'b0, m_mask}); wr(3'd3, {3'b000, m_en, 4'h0});
            end
            if ($urandom % 6 == 0) begin
                wr(3'd4, 8'h01); m_flag = 1'b0;
            end
            begin
                int mi, hr, wd;
                mi = ($urandom % 4 == 0) ? m_min : ($urandom % 60);
                hr = ($urandom % 3 == 0) ? m_hour : ($urandom % 24);
                wd = $urandom % 8;
                if ($urandom % 4 == 0) begin mi = m_min; hr = m_hour; end
                tick(mi, hr, wd);
                chk("R3 random flag", alarm_flag, m_flag);
                chk("R7 random irq", irq, m_flag && m_en);
            end
        end
        report();
    end

endmodule